// File: doc/BRIEF.md
# Serial Autobaud Measurement Unit

The block watches an asynchronous serial receive line and measures the low pulse that opens a character. The first falling edge after the block is armed starts a saturating timer. The timer counts system clock cycles until the line goes high again. That count is taken as one bit period. The block then samples the rest of the character near the middle of each bit, using the measured period, and shifts the samples into a capture register.

When the last sample is in, a done flag rises. The measured width, an overflow flag and the captured bits stay frozen until the block is armed again, so software can read them and work out the baud rate, the parity and the character length.

Low pulses shorter than a programmable minimum are treated as noise. They are discarded and the block keeps listening. A separate path gives a copy of the serial input whose pass-through can be switched on and off; while it is switched off, that output rests at the idle (mark) level.

Top module: `serial_baud_probe`

## Requirements
- R1: After reset, `done_o` is 0, `width_o` and `bits_o` are all zeros, `ovf_o` is 0, and the block ignores the line until `arm_i` is pulsed.
- R2: A one-cycle high pulse on `arm_i` clears `done_o` in the next cycle and makes the block listen for a falling edge. While not armed, falling edges on `rxd_i` change neither `width_o` nor `done_o`.
- R3: The measured width is the number of clock cycles that `rxd_i` stays low from the falling edge up to the next rising edge. The count saturates at 2^CNT_W-1, and in that case `ovf_o` reads 1; otherwise `ovf_o` reads 0. A correct measurement requires that the first bit after the start bit is a 1.
- R4: A low pulse whose width is below `min_width_i` is discarded: `width_o` keeps its value, `done_o` stays 0 and the block waits for the next falling edge. A width equal to `min_width_i` is accepted.
- R5: After an accepted start bit, NBITS samples (default 10) are taken one measured period apart. The first sample is taken floor(W/2)+1 cycles into the first bit. The samples are stored LSB first: `bits_o[0]` holds the first bit after the start bit and `bits_o[NBITS-1]` holds the last.
- R6: `done_o` rises in the cycle in which the last sample is stored. It then holds, with `width_o`, `ovf_o` and `bits_o` unchanged, whatever the line does, until the next `arm_i` pulse.
- R7: With `pass_en_i` = 1, `txd_o` equals `rxd_i` in the same cycle. With `pass_en_i` = 0, `txd_o` is 1.
- R8: A start bit of 173 cycles (115.2 kbit/s at a 20 MHz clock) is measured exactly and its character is captured correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| arm_i | input | 1 | One-cycle pulse that starts a new measurement |
| min_width_i | input | CNT_W | Shortest start bit accepted, in clock cycles |
| pass_en_i | input | 1 | Enables the serial pass-through |
| txd_o | output | 1 | Gated copy of the serial line |
| width_o | output | CNT_W | Measured start-bit width in clock cycles |
| ovf_o | output | 1 | Width counter saturated |
| bits_o | output | NBITS | Captured bits, first received in bit 0 |
| done_o | output | 1 | Measurement and capture complete |

## Verification
The bench probes the width boundary around the glitch threshold: a pulse one cycle below the minimum must be dropped, and one exactly at the minimum must be kept. A design with an off-by-one comparison would either report a noise pulse as a baud measurement or refuse a legal fast rate. It also holds the line low well past the counter range. A counter that wraps instead of saturating would report a tiny width, sample far too fast and leave `ovf_o` low. Finally, it sends a whole character while the block is unarmed and another after done. A block that does not freeze its results would overwrite the measurement that software is about to read.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
   typedef enum logic [2:0] {
      SBP_IDLE,
      SBP_ARMED,
      SBP_MEAS,
      SBP_SAMP,
      SBP_DONE
   } sbp_state_e;
endpackage

// File: rtl/sbp_edge.sv
// Synchronises the serial line and flags its falling and rising edges.
module sbp_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rxd_i,
   output logic line_o,
   output logic fall_o,
   output logic rise_o
);
   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;

   genvar s;
   generate
      for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= 1'b1;
               else         chain_q[s] <= rxd_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= 1'b1;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign line_o = chain_q[SYNC_STAGES-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= line_o;
   end

   assign fall_o = prev_q & ~line_o;
   assign rise_o = ~prev_q & line_o;
endmodule

// File: rtl/sbp_timer.sv
// Saturating cycle counter for the start-bit width.
module sbp_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             sat_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= CNT_W'(1);
      end else if (inc_i && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o = cnt_q;
   assign sat_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/sbp_sampler.sv
// Mid-bit sampler: shifts NBITS samples in, LSB first, one period apart.
module sbp_sampler #(
   parameter int CNT_W = 16,
   parameter int NBITS = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] half_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic             run_i,
   input  logic             line_i,
   output logic [NBITS-1:0] bits_o,
   output logic             last_o
);
   localparam int NB_W = $clog2(NBITS + 1);

   logic [CNT_W-1:0] tmr_q;
   logic [NB_W-1:0]  nb_q;
   logic [NBITS-1:0] bits_q;
   logic             tick;

   assign tick   = run_i && (tmr_q == '0);
   assign last_o = tick && (nb_q == NB_W'(NBITS - 1));
   assign bits_o = bits_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tmr_q  <= '0;
         nb_q   <= '0;
         bits_q <= '0;
      end else if (load_i) begin
         tmr_q  <= half_i;
         nb_q   <= '0;
         bits_q <= '0;
      end else if (run_i) begin
         if (tick) begin
            bits_q <= {line_i, bits_q[NBITS-1:1]};
            tmr_q  <= period_i - CNT_W'(1);
            nb_q   <= nb_q + NB_W'(1);
         end else begin
            tmr_q <= tmr_q - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/serial_baud_probe.sv
module serial_baud_probe #(
   parameter int CNT_W       = 16,
   parameter int NBITS       = 10,
   parameter int SYNC_STAGES = 2,
   parameter bit GATE_REG    = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rxd_i,
   input  logic             arm_i,
   input  logic [CNT_W-1:0] min_width_i,
   input  logic             pass_en_i,
   output logic             txd_o,
   output logic [CNT_W-1:0] width_o,
   output logic             ovf_o,
   output logic [NBITS-1:0] bits_o,
   output logic             done_o
);
   import sbp_pkg::*;

   generate
      if (CNT_W < 4) begin : g_bad_cnt
         $error("serial_baud_probe: CNT_W must be at least 4");
      end
      if (NBITS < 2) begin : g_bad_nbits
         $error("serial_baud_probe: NBITS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serial_baud_probe: SYNC_STAGES must be at least 2");
      end
   endgenerate

   sbp_state_e       state_q, state_d;
   logic             line, fall, rise;
   logic             tmr_start, tmr_inc, tmr_sat;
   logic [CNT_W-1:0] tmr_cnt;
   logic             smp_load, smp_last, accept;
   logic [CNT_W-1:0] width_q;
   logic             ovf_q;

   sbp_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rxd_i  (rxd_i),
      .line_o (line),
      .fall_o (fall),
      .rise_o (rise)
   );

   sbp_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (tmr_start),
      .inc_i   (tmr_inc),
      .cnt_o   (tmr_cnt),
      .sat_o   (tmr_sat)
   );

   sbp_sampler #(.CNT_W(CNT_W), .NBITS(NBITS)) u_sampler (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (smp_load),
      .half_i   (tmr_cnt >> 1),
      .period_i (width_q),
      .run_i    (state_q == SBP_SAMP),
      .line_i   (line),
      .bits_o   (bits_o),
      .last_o   (smp_last)
   );

   always_comb begin
      state_d   = state_q;
      tmr_start = 1'b0;
      tmr_inc   = 1'b0;
      smp_load  = 1'b0;
      accept    = 1'b0;
      if (arm_i) begin
         state_d = SBP_ARMED;
      end else begin
         unique case (state_q)
            SBP_ARMED: begin
               if (fall) begin
                  state_d   = SBP_MEAS;
                  tmr_start = 1'b1;
               end
            end
            SBP_MEAS: begin
               if (rise) begin
                  if (tmr_cnt >= min_width_i) begin
                     state_d  = SBP_SAMP;
                     smp_load = 1'b1;
                     accept   = 1'b1;
                  end else begin
                     state_d = SBP_ARMED;
                  end
               end else begin
                  tmr_inc = 1'b1;
               end
            end
            SBP_SAMP: begin
               if (smp_last) state_d = SBP_DONE;
            end
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SBP_IDLE;
         width_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            width_q <= tmr_cnt;
            ovf_q   <= tmr_sat;
         end
      end
   end

   assign width_o = width_q;
   assign ovf_o   = ovf_q;
   assign done_o  = (state_q == SBP_DONE);

   generate
      if (GATE_REG) begin : g_pass_reg
         logic txd_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) txd_q <= 1'b1;
            else         txd_q <= rxd_i | ~pass_en_i;
         end
         assign txd_o = txd_q;
      end else begin : g_pass_comb
         assign txd_o = rxd_i | ~pass_en_i;
      end
   endgenerate
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
   parameter int CNT_W       = 16,
   parameter int NBITS       = 10,
   parameter int SYNC_STAGES = 2,
   parameter bit GATE_REG    = 1'b0
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             rxd_i,
   input logic             arm_i,
   input logic [CNT_W-1:0] min_width_i,
   input logic             pass_en_i,
   input logic             txd_o,
   input logic [CNT_W-1:0] width_o,
   input logic             ovf_o,
   input logic [NBITS-1:0] bits_o,
   input logic             done_o
);
   localparam logic [CNT_W-1:0] CHK_MAX = {CNT_W{1'b1}};

   AST_ARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_i |=> !done_o); // R2

   AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && !arm_i |=> done_o); // R6

   AST_RESULT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && !arm_i |=> $stable(width_o) && $stable(bits_o) && $stable(ovf_o)); // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |-> width_o == CHK_MAX); // R3

   AST_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> width_o >= min_width_i); // R4

   AST_PASS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!GATE_REG && !pass_en_i) |-> txd_o); // R7
endmodule

bind serial_baud_probe sbp_checker #(
   .CNT_W(CNT_W), .NBITS(NBITS), .SYNC_STAGES(SYNC_STAGES), .GATE_REG(GATE_REG)
) u_chk (.*);

// File: tb/sim_serial_baud_probe.sv
`timescale 1ns/1ps
module sim_serial_baud_probe;
   localparam int CW = 10;
   localparam int NB = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rxd = 1'b1;
   logic          arm = 1'b0;
   logic [CW-1:0] min_w = CW'(4);
   logic          pen = 1'b0;
   logic          txd, ovf, done;
   logic [CW-1:0] width;
   logic [NB-1:0] bits;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   serial_baud_probe #(.CNT_W(CW), .NBITS(NB)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .arm_i(arm),
      .min_width_i(min_w), .pass_en_i(pen), .txd_o(txd),
      .width_o(width), .ovf_o(ovf), .bits_o(bits), .done_o(done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_arm();
      @(negedge clk); arm = 1'b1;
      @(negedge clk); arm = 1'b0;
   endtask

   // start bit of w cycles, then pattern LSB first, each w cycles, then idle
   task automatic send(input int w, input logic [NB-1:0] pat);
      @(negedge clk); rxd = 1'b0;
      cyc(w);
      for (int i = 0; i < NB; i++) begin
         rxd = pat[i];
         cyc(w);
      end
      rxd = 1'b1;
      cyc(2 * w + 8);
   endtask

   task automatic t_reset();
      cyc(1);
      chk(done == 1'b0, "R1 done", 32'(done), 0);
      chk(width == '0, "R1 width", 32'(width), 0);
      chk(bits == '0, "R1 bits", 32'(bits), 0);
      chk(ovf == 1'b0, "R1 ovf", 32'(ovf), 0);
   endtask

   task automatic t_unarmed();
      send(8, {2'b01, 8'h41});
      chk(done == 1'b0, "R2 unarmed done", 32'(done), 0);
      chk(width == '0, "R2 unarmed width", 32'(width), 0);
   endtask

   task automatic t_pass();
      @(negedge clk); pen = 1'b0; rxd = 1'b0; #1;
      chk(txd == 1'b1, "R7 gated idle", 32'(txd), 1);
      pen = 1'b1; #1;
      chk(txd == 1'b0, "R7 pass low", 32'(txd), 0);
      rxd = 1'b1; #1;
      chk(txd == 1'b1, "R7 pass high", 32'(txd), 1);
      pen = 1'b0; cyc(4);
   endtask

   task automatic t_glitch();
      do_arm();
      chk(done == 1'b0, "R2 armed clear", 32'(done), 0);
      rxd = 1'b0; cyc(3); rxd = 1'b1; cyc(20);
      chk(done == 1'b0, "R4 glitch done", 32'(done), 0);
      chk(width == '0, "R4 glitch width", 32'(width), 0);
   endtask

   task automatic t_frame(input int w, input logic [NB-1:0] pat, input string req);
      send(w, pat);
      chk(done == 1'b1, {req, " done"}, 32'(done), 1);
      chk(width == CW'(w), {req, " width"}, 32'(width), 32'(w));
      chk(bits == pat, {req, " R5 bits"}, 32'(bits), 32'(pat));
      chk(ovf == 1'b0, {req, " ovf"}, 32'(ovf), 0);
   endtask

   task automatic t_frozen();
      send(16, {2'b10, 8'h55});
      chk(done == 1'b1, "R6 hold done", 32'(done), 1);
      chk(width == CW'(8), "R6 hold width", 32'(width), 8);
      chk(bits == {2'b10, 8'h41}, "R6 hold bits", 32'(bits), 32'({2'b10, 8'h41}));
      do_arm();
      chk(done == 1'b0, "R2 rearm clears done", 32'(done), 0);
   endtask

   task automatic t_overflow();
      do_arm();
      @(negedge clk); rxd = 1'b0; cyc(1100); rxd = 1'b1;
      cyc(1023 * 11 + 100);
      chk(done == 1'b1, "R3 sat done", 32'(done), 1);
      chk(width == '1, "R3 sat width", 32'(width), 32'(1023));
      chk(ovf == 1'b1, "R3 ovf set", 32'(ovf), 1);
      chk(bits == '1, "R3 sat bits", 32'(bits), 32'(10'h3ff));
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      t_reset();
      t_unarmed();
      t_pass();
      t_glitch();
      t_frame(8, {2'b10, 8'h41}, "R3 w8");
      t_frozen();
      t_frame(16, {2'b10, 8'h55}, "R5 w16");
      do_arm();
      t_frame(4, {2'b11, 8'h01}, "R4 at minimum");
      do_arm();
      t_frame(173, {2'b11, 8'h0D}, "R8 fast rate");
      t_overflow();
      do_arm();
      t_frame(12, {2'b10, 8'hA3}, "R3 ovf cleared");
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule